// File: doc/BRIEF.md
# MII management frame unit

This block lets a host reach the registers of an Ethernet PHY over the two-wire management bus (MDC clock, bidirectional MDIO data). The host writes one 32-bit frame word into the frame register. That word holds the start code, the opcode, the PHY address, the register address, two turnaround bits and sixteen data bits. The unit then checks the word. A word it accepts is sent on the bus as a 32-bit all-ones preamble followed by the frame, most significant bit first. On a read, the unit samples the sixteen bits the PHY returns. When the transaction is over, it sets the low turnaround bit of the frame register. The host polls that bit to learn that the transaction has completed.

Some words are answered at once, with no bus activity: a word with a bad start code, with an address other than the selected PHY, or with an opcode that is neither read nor write. Such a word is stored with its low turnaround bit already set. A second register carries configuration. Two of its bits are read-only and show which transceivers are attached.

The controller is a state machine with these states:
- S_IDLE: the bus is quiet.
- S_PRE: sends the preamble.
- S_CMD: sends the fourteen bits of start code, opcode, PHY address and register address.
- S_TURN: the two turnaround bit times.
- S_DATA: sixteen data bit times.
- S_FINISH: a single cycle that writes the result back.

The transitions are:
- S_IDLE to S_PRE, on an accepted frame write.
- S_PRE to S_CMD, after the last preamble bit.
- S_CMD to S_TURN, after the register address LSB.
- S_TURN to S_DATA, after the second turnaround bit.
- S_DATA to S_FINISH, after data bit 0.
- S_FINISH to S_IDLE, unconditionally.

Every bit-time transition is taken on a falling MDC edge.

Top module: `mgmt_frame_unit`

## Requirements
- R1: After reset the frame register reads 0, MDC is low and MDIO output enable is low.
- R2: A frame write is accepted when the unit is idle, bits [31:30] are 01, bits [27:23] equal PHY_SEL and bits [29:28] are 01 or 10. The unit then sends 32 one-bits of preamble and the 32 frame bits MSB first. Bit 16 reads 0 while the transaction is in progress.
- R3: For opcode 01 (write), the PHY receives the register address from [22:18] and the data from [15:0], with the turnaround driven as 1 then 0. On completion, bit 16 becomes 1 and all other bits keep the written value.
- R4: For opcode 10 (read), the unit releases MDIO for the two turnaround bits and the sixteen data bits. It samples the data on rising MDC edges, MSB first. On completion, [15:0] is replaced by the returned value and bit 16 becomes 1.
- R5: A frame word whose bits [31:30] are not 01 starts no bus transaction. The register stores the word with bit 16 set, visible on the next cycle.
- R6: A frame word whose PHY address [27:23] differs from PHY_SEL starts no bus transaction and is stored with bit 16 set.
- R7: A frame word with a valid start code and PHY address but opcode 00 or 11 starts no bus transaction and is stored with bit 16 set.
- R8: A frame write while a transaction is in progress is ignored. It changes neither the register nor the bus transaction.
- R9: The configuration register (reg_sel=1) reads xcvr_sense in bits [9:8]. Host writes to bits [9:8] are ignored, and all other bits read back as written (reset value 0).
- R10: MDC has a period of 2*HALF_DIV clock cycles during a transaction, and it is low whenever no transaction is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 frame, 1 configuration |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| xcvr_sense | input | 2 | Transceiver-attached indications shown in configuration bits [9:8] |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions assume that the host changes reg_sel, reg_we and reg_wdata only between clock edges. They also assume that the PHY drives MDIO only while the unit has released it during a read. The bench's behavioural PHY keeps to this: it changes MDIO only on falling MDC edges inside the read turnaround and data window, and it releases the line after the last data bit. The bench writes frame words at falling clock edges. It issues a second frame write during a transaction only to exercise the busy-ignore rule.

// File: rtl/mfu_pkg.sv
`timescale 1ns/1ps
package mfu_pkg;
    localparam int WORD_W    = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int PHY_W     = 5;
    localparam int BIT_DONE  = 16;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_CMD,
        S_TURN,
        S_DATA,
        S_FINISH
    } mfu_state_e;
endpackage

// File: rtl/mfu_mdc_gen.sv
`timescale 1ns/1ps
module mfu_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          tick;

    assign tick = run && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc  = mdc_q;
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
endmodule

// File: rtl/mfu_engine.sv
`timescale 1ns/1ps
module mfu_engine
    import mfu_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 is_read,
    input  logic [HDR_BITS-1:0]  hdr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 run,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_BITS-1:0] rdata
);
    localparam int CNTW = $clog2((PRE_LEN > 16) ? PRE_LEN : 16) + 1;
    localparam logic [CNTW-1:0] PRE_LAST  = CNTW'(PRE_LEN - 1);
    localparam logic [CNTW-1:0] CMD_LAST  = CNTW'(HDR_BITS - 1);
    localparam logic [CNTW-1:0] TA_LAST   = CNTW'(TA_BITS - 1);
    localparam logic [CNTW-1:0] DATA_LAST = CNTW'(DATA_BITS - 1);

    mfu_state_e            state;
    logic [CNTW-1:0]       cnt;
    logic [HDR_BITS-1:0]   hdr_q;
    logic [DATA_BITS-1:0]  data_q;
    logic                  read_q;

    // state register and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            hdr_q  <= '0;
            data_q <= '0;
            read_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state  <= S_PRE;
                        cnt    <= '0;
                        hdr_q  <= hdr;
                        data_q <= wdata;
                        read_q <= is_read;
                    end
                end
                S_PRE: begin
                    if (fall) begin
                        if (cnt == PRE_LAST) begin
                            state <= S_CMD;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_CMD: begin
                    if (fall) begin
                        if (cnt == CMD_LAST) begin
                            state <= S_TURN;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_TURN: begin
                    if (fall) begin
                        if (cnt == TA_LAST) begin
                            state <= S_DATA;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (rise && read_q) begin
                        data_q <= {data_q[DATA_BITS-2:0], mdio_i};
                    end
                    if (fall) begin
                        if (cnt == DATA_LAST) begin
                            state <= S_FINISH;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_FINISH: begin
                    state <= S_IDLE;
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        run     = 1'b0;
        done    = 1'b0;
        unique case (state)
            S_IDLE: begin
            end
            S_PRE: begin
                run     = 1'b1;
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            S_CMD: begin
                run     = 1'b1;
                mdio_oe = 1'b1;
                mdio_o  = hdr_q[4'd13 - cnt[3:0]];
            end
            S_TURN: begin
                run     = 1'b1;
                mdio_oe = !read_q;
                mdio_o  = (cnt == '0);
            end
            S_DATA: begin
                run     = 1'b1;
                mdio_oe = !read_q;
                mdio_o  = data_q[4'd15 - cnt[3:0]];
            end
            S_FINISH: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign rdata = data_q;
endmodule

// File: rtl/mfu_regs.sv
`timescale 1ns/1ps
module mfu_regs
    import mfu_pkg::*;
#(
    parameter int PHY_SEL = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_we,
    input  logic [WORD_W-1:0]    reg_wdata,
    input  logic [1:0]           xcvr_sense,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] rdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [WORD_W-1:0]    frame,
    output logic                 busy,
    output logic                 start,
    output logic                 is_read,
    output logic [HDR_BITS-1:0]  hdr,
    output logic [DATA_BITS-1:0] wdata
);
    localparam logic [WORD_W-1:0] DONE_MASK = WORD_W'(1) << BIT_DONE;
    localparam logic [WORD_W-1:0] RO_MASK   = WORD_W'(3) << 8;

    logic [WORD_W-1:0] frame_q;
    logic [WORD_W-1:0] cfg_q;
    logic              busy_q;
    logic              accept;
    logic              valid;
    logic [1:0]        w_st;
    logic [1:0]        w_op;
    logic [PHY_W-1:0]  w_phy;

    assign w_st   = reg_wdata[31:30];
    assign w_op   = reg_wdata[29:28];
    assign w_phy  = reg_wdata[27:23];
    assign valid  = (w_st == START_CODE) && (w_phy == PHY_W'(PHY_SEL)) &&
                    ((w_op == OP_WRITE) || (w_op == OP_READ));
    assign accept = reg_we && !reg_sel && !busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            busy_q  <= 1'b0;
        end else if (accept) begin
            if (valid) begin
                frame_q <= reg_wdata & ~DONE_MASK;
                busy_q  <= 1'b1;
            end else begin
                frame_q <= reg_wdata | DONE_MASK;
            end
        end else if (done) begin
            busy_q            <= 1'b0;
            frame_q[BIT_DONE] <= 1'b1;
            if (frame_q[29:28] == OP_READ) begin
                frame_q[DATA_BITS-1:0] <= rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reg_we && reg_sel) begin
            cfg_q <= reg_wdata & ~RO_MASK;
        end
    end

    assign reg_rdata = reg_sel ? (cfg_q | (WORD_W'(xcvr_sense) << 8)) : frame_q;
    assign frame     = frame_q;
    assign busy      = busy_q;
    assign start     = accept && valid;
    assign is_read   = (w_op == OP_READ);
    assign hdr       = reg_wdata[31:18];
    assign wdata     = reg_wdata[DATA_BITS-1:0];
endmodule

// File: rtl/mgmt_frame_unit.sv
`timescale 1ns/1ps
module mgmt_frame_unit
    import mfu_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int PRE_LEN  = 32,
    parameter int PHY_SEL  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  xcvr_sense,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic                 busy;
    logic                 done;
    logic                 run;
    logic                 start;
    logic                 is_read;
    logic                 rise;
    logic                 fall;
    logic [HDR_BITS-1:0]  hdr;
    logic [DATA_BITS-1:0] wdata;
    logic [DATA_BITS-1:0] rdata;
    logic [WORD_W-1:0]    frame;

    mfu_regs #(.PHY_SEL(PHY_SEL)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .xcvr_sense(xcvr_sense), .done(done),
        .rdata(rdata), .reg_rdata(reg_rdata), .frame(frame), .busy(busy),
        .start(start), .is_read(is_read), .hdr(hdr), .wdata(wdata)
    );

    mfu_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(run), .mdc(mdc), .rise(rise), .fall(fall)
    );

    mfu_engine #(.PRE_LEN(PRE_LEN)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
        .hdr(hdr), .wdata(wdata), .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
        .rdata(rdata)
    );
endmodule

// File: rtl/mfu_checker.sv
`timescale 1ns/1ps
module mfu_checker #(
    parameter int PHY_SEL = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_sel,
    input logic        reg_we,
    input logic [31:0] reg_wdata,
    input logic [31:0] frame,
    input logic        busy,
    input logic        done,
    input logic        run,
    input logic        mdc,
    input logic        mdio_oe
);
    logic host_wr;
    logic good_word;
    assign host_wr   = reg_we && !reg_sel;
    assign good_word = (reg_wdata[31:30] == 2'b01) &&
                       (reg_wdata[27:23] == 5'(PHY_SEL)) &&
                       ((reg_wdata[29:28] == 2'b01) || (reg_wdata[29:28] == 2'b10));

    // R10
    idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && !done) |=> $stable(frame));

    // R5
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && (reg_wdata[31:30] != 2'b01)) |=>
        (frame[16] && !busy && (frame[31:17] == $past(reg_wdata[31:17]))));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && good_word) |=> (busy && !frame[16]));

    // R4
    finish_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mdio_oe && !mdc));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && frame[16]));
endmodule

bind mgmt_frame_unit mfu_checker #(.PHY_SEL(PHY_SEL)) u_mfu_checker (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .frame(frame), .busy(busy), .done(done),
    .run(run), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/test_mgmt_frame_unit.sv
`timescale 1ns/1ps
module test_mgmt_frame_unit;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  xcvr_sense = 2'b01;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        sdrv = 1'b0;
    logic        sval = 1'b0;
    wire         mdio_bus = mdio_oe ? mdio_o : (sdrv ? sval : 1'b1);

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mgmt_frame_unit #(.HALF_DIV(HALF), .PRE_LEN(32), .PHY_SEL(1)) i_mgmt_frame_unit (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xcvr_sense(xcvr_sense),
        .mdc(mdc), .mdio_i(mdio_bus), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(input logic [1:0] st, input logic [1:0] op,
                                           input logic [4:0] phy, input logic [4:0] ra,
                                           input logic [15:0] d);
        return {st, op, phy, ra, 2'b00, d};
    endfunction

    // behavioural PHY
    logic [15:0] phy_mem [32];
    int          txn_cnt = 0;
    int          last_pre = 0;
    logic [1:0]  last_ta = 2'b00;
    logic [4:0]  last_reg = '0;
    logic [4:0]  last_phy = '0;
    realtime     prev_rise = 0.0;
    realtime     mdc_per = 0.0;

    always @(posedge mdc) begin
        mdc_per   = $realtime - prev_rise;
        prev_rise = $realtime;
    end

    initial begin
        int ones;
        logic [12:0] h;
        logic [15:0] d;
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'hA500 + 16'(i * 3);
        ones = 0;
        forever begin
            @(posedge mdc);
            if (mdio_bus === 1'b1) begin
                ones++;
            end else if (ones >= 32) begin
                last_pre = ones;
                for (int i = 0; i < 13; i++) begin
                    @(posedge mdc);
                    h = {h[11:0], mdio_bus};
                end
                txn_cnt++;
                last_phy = h[9:5];
                last_reg = h[4:0];
                if (h[11:10] == 2'b10) begin
                    @(negedge mdc); sdrv = 1'b0;
                    @(posedge mdc);
                    @(negedge mdc); sdrv = 1'b1; sval = 1'b0;
                    @(posedge mdc);
                    for (int i = 0; i < 16; i++) begin
                        @(negedge mdc); sval = phy_mem[last_reg][15-i];
                        @(posedge mdc);
                    end
                    @(negedge mdc); sdrv = 1'b0;
                end else begin
                    for (int i = 0; i < 2; i++) begin
                        @(posedge mdc); last_ta = {last_ta[0], mdio_bus};
                    end
                    for (int i = 0; i < 16; i++) begin
                        @(posedge mdc); d = {d[14:0], mdio_bus};
                    end
                    phy_mem[last_reg] = d;
                end
                ones = 0;
            end else begin
                ones = 0;
            end
        end
    end

    // scoreboard
    logic [31:0] exp_q[$];
    int          mon_done = 0;
    string       cur_tag = "";

    initial begin
        logic [31:0] e;
        forever begin
            wait (exp_q.size() > 0);
            do @(negedge clk); while (reg_sel || (reg_rdata[16] !== 1'b1));
            e = exp_q.pop_front();
            chk(cur_tag, reg_rdata, e);
            mon_done++;
        end
    end

    task automatic host_write(input logic sel, input logic [31:0] w);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic post(input string tag, input logic [31:0] exp);
        cur_tag = tag;
        exp_q.push_back(exp);
    endtask

    task automatic finish_wait();
        int target;
        target = mon_done + exp_q.size();
        wait (mon_done == target);
    endtask

    task automatic send(input string tag, input logic [31:0] w, input logic [31:0] exp);
        host_write(1'b0, w);
        post(tag, exp);
        finish_wait();
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w, a;
        int t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 frame", reg_rdata, 32'h0);
        chk("R1 mdc", {31'b0, mdc}, 32'h0);
        chk("R1 oe", {31'b0, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 configuration read-only bits
        host_write(1'b1, 32'hFFFF_FFFF);
        reg_sel = 1'b1; #1;
        chk("R9 cfg ones", reg_rdata, 32'hFFFF_FDFF);
        reg_sel = 1'b0;
        xcvr_sense = 2'b10;
        host_write(1'b1, 32'h0);
        reg_sel = 1'b1; #1;
        chk("R9 cfg zero", reg_rdata, 32'h0000_0200);
        reg_sel = 1'b0;

        // R3 write
        w = mkword(2'b01, 2'b01, 5'd1, 5'd5, 16'h1234);
        send("R3 write frame", w, w | 32'h0001_0000);
        chk("R3 phy data", {16'h0, phy_mem[5]}, 32'h1234);
        chk("R3 turnaround", {30'h0, last_ta}, 32'h2);
        chk("R3 reg addr", {27'h0, last_reg}, 32'd5);
        chk("R2 preamble", last_pre, 32'd32);
        chk("R2 txn count", txn_cnt, 32'd1);
        chk("R10 mdc period", int'(mdc_per), 32'd80);
        chk("R10 mdc idle low", {31'b0, mdc}, 32'h0);

        // R4 reads
        w = mkword(2'b01, 2'b10, 5'd1, 5'd5, 16'h0000);
        send("R4 read back", w, {w[31:17], 1'b1, 16'h1234});
        w = mkword(2'b01, 2'b10, 5'd1, 5'd7, 16'hFFFF);
        send("R4 read init", w, {w[31:17], 1'b1, 16'hA515});
        chk("R4 txn count", txn_cnt, 32'd3);

        // R5 bad start codes
        w = mkword(2'b00, 2'b01, 5'd1, 5'd5, 16'h5555);
        send("R5 start 00", w, w | 32'h0001_0000);
        w = mkword(2'b11, 2'b10, 5'd1, 5'd5, 16'h0F0F);
        send("R5 start 11", w, w | 32'h0001_0000);
        // R6 other PHY
        w = mkword(2'b01, 2'b01, 5'd0, 5'd5, 16'h7777);
        send("R6 phy 0", w, w | 32'h0001_0000);
        w = mkword(2'b01, 2'b10, 5'd2, 5'd5, 16'h0000);
        send("R6 phy 2", w, w | 32'h0001_0000);
        // R7 other opcodes
        w = mkword(2'b01, 2'b00, 5'd1, 5'd5, 16'h1111);
        send("R7 op 00", w, w | 32'h0001_0000);
        w = mkword(2'b01, 2'b11, 5'd1, 5'd5, 16'h2222);
        send("R7 op 11", w, w | 32'h0001_0000);
        repeat (50) @(negedge clk);
        chk("R5 R6 R7 no bus txn", txn_cnt, 32'd3);
        chk("R5 R6 R7 phy reg kept", {16'h0, phy_mem[5]}, 32'h1234);

        // R8 write while busy, R2 in-progress flag
        a = mkword(2'b01, 2'b01, 5'd1, 5'd9, 16'hBEEF);
        host_write(1'b0, a);
        chk("R2 busy flag clear", reg_rdata, a);
        post("R8 first frame", a | 32'h0001_0000);
        repeat (40) @(negedge clk);
        host_write(1'b0, mkword(2'b01, 2'b01, 5'd1, 5'd9, 16'h0000));
        chk("R8 frame unchanged", reg_rdata, a);
        finish_wait();
        t0 = txn_cnt;
        repeat (300) @(negedge clk);
        chk("R8 single txn", t0, 32'd4);
        chk("R8 txn count stable", txn_cnt, 32'd4);
        chk("R8 phy data", {16'h0, phy_mem[9]}, 32'hBEEF);
        chk("R8 frame kept", reg_rdata, a | 32'h0001_0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule